// File: doc/BRIEF.md
# Round-Robin Warp Issue Selector

This block decides which warp a multi-warp processor front end fetches from next. It holds a pointer to the warp that currently owns the fetch slot. On each permitted advance it scans the other warps in circular order, starting just after the current owner, and picks the first one that can run. A warp can run when it has at least one live thread and is not held by a warp-control stall. The current owner is examined last, so when it is the only runnable warp it keeps the slot.

The block keeps one stall bit per warp. A warp-control instruction raises the bit through a set strobe, and the matching writeback lowers it through a release strobe. Both strobes affect the search in the same cycle they arrive. When a full lap finds no runnable warp, the found flag drops and the pointer stays where it was until a later advance succeeds.

A two-state machine tracks ownership:
- `SEL_OWNED`: the flag is high.
- `SEL_EMPTY`: the flag is low.
- Transition LOSE (`SEL_OWNED` to `SEL_EMPTY`): a permitted advance whose lap finds nobody.
- Transition REGAIN (`SEL_EMPTY` to `SEL_OWNED`): a permitted advance that finds a warp.
- Every other case keeps the current state.

Top module: `warp_issue_selector`

## Requirements
- R1: After reset the selected index is 0, the found flag is 1 and every stall bit is clear.
- R2: The selection moves only on a clock edge where `advance_i` is 1 and both `issue_stall_i` and `fetch_stall_i` are 0. On any other edge the index and the found flag hold their values.
- R3: A permitted advance tests warps in the order idx+1, idx+2, … modulo the warp count, with the current idx tested last. The first runnable warp in that order becomes the new index, visible after that edge.
- R4: Warp w is runnable when `active_i[w]` is 1 and its stall bit, as updated by this cycle's strobes, is 0.
- R5: When a permitted advance finds no runnable warp, the found flag goes to 0 and the index keeps its value. The next permitted advance that finds a warp sets the flag back to 1.
- R6: A pulse on `stall_set_i[w]` sets warp w's stall bit, and the bit stays set until a pulse on `stall_clr_i[w]`. A set arriving in the same cycle as an advance already excludes w from that advance.
- R7: When `stall_set_i[w]` and `stall_clr_i[w]` are both 1 in one cycle, the release wins: the bit ends up clear and w counts as unstalled in that cycle's search.
- R8: When the current owner is the only runnable warp, a permitted advance reselects it with the found flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_i | input | NUM_WARPS | Per-warp flag: warp has live threads |
| stall_set_i | input | NUM_WARPS | Per-warp strobe that raises the stall bit |
| stall_clr_i | input | NUM_WARPS | Per-warp strobe that lowers the stall bit (wins over set) |
| advance_i | input | 1 | Request to pick the next warp |
| issue_stall_i | input | 1 | Downstream issue stage is stalled; blocks advance |
| fetch_stall_i | input | 1 | Fetch stall pending; blocks advance |
| warp_idx_o | output | $clog2(NUM_WARPS) | Selected warp index |
| found_o | output | 1 | Selected warp is valid (a lap found a candidate) |

## Verification
The bench builds the selector with NUM_WARPS = 4. At that size the state space is small enough to sweep in full:
- every starting owner;
- every one of the 16 live-thread patterns;
- every one of the 16 stall-bit patterns.

Each of these combinations is checked against an arithmetic circular scan. Directed sequences at the same size cover the rest: same-cycle set and release conflicts, a stall set during a search, stall-bit persistence, blocked advances, and recovery from an empty lap.

// File: rtl/warp_sel_pkg.sv
package warp_sel_pkg;

    // Ownership state of the issue slot
    typedef enum logic {
        SEL_OWNED = 1'b0,
        SEL_EMPTY = 1'b1
    } sel_state_e;

endpackage

// File: rtl/warp_stall_bits.sv
module warp_stall_bits #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] set_i,
    input  logic [NW-1:0] clr_i,
    output logic [NW-1:0] stall_next_o,
    output logic [NW-1:0] stall_q_o
);

    for (genvar w = 0; w < NW; w++) begin : g_bit
        // Release has priority over set
        assign stall_next_o[w] = (stall_q_o[w] | set_i[w]) & ~clr_i[w];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stall_q_o[w] <= 1'b0;
            end else begin
                stall_q_o[w] <= stall_next_o[w];
            end
        end
    end

    // R7
    release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((stall_q_o & $past(set_i & clr_i)) == '0));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(stall_q_o));

    // R6
    stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~clr_i)) |=> ((stall_q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker #(
    parameter int NW = 8,
    parameter int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [IW-1:0] base_i,
    input  logic [NW-1:0] elig_i,
    output logic          hit_o,
    output logic [IW-1:0] winner_o
);

    logic [NW-1:0] rot;
    logic [IW-1:0] offs;

    // Rotate so that position 0 holds warp base+1 and position NW-1 holds base
    always_comb begin
        for (int k = 0; k < NW; k++) begin
            rot[k] = elig_i[IW'(base_i + IW'(k + 1))];
        end
    end

    // Priority encode the lowest set position
    always_comb begin
        hit_o = 1'b0;
        offs  = '0;
        for (int k = 0; k < NW; k++) begin
            if (!hit_o && rot[k]) begin
                hit_o = 1'b1;
                offs  = IW'(k);
            end
        end
    end

    assign winner_o = hit_o ? IW'(base_i + offs + IW'(1)) : base_i;

endmodule

// File: rtl/warp_issue_selector.sv
module warp_issue_selector #(
    parameter int NUM_WARPS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WARPS-1:0]         active_i,
    input  logic [NUM_WARPS-1:0]         stall_set_i,
    input  logic [NUM_WARPS-1:0]         stall_clr_i,
    input  logic                         advance_i,
    input  logic                         issue_stall_i,
    input  logic                         fetch_stall_i,
    output logic [$clog2(NUM_WARPS)-1:0] warp_idx_o,
    output logic                         found_o
);
    import warp_sel_pkg::*;

    localparam int IW = $clog2(NUM_WARPS);

    sel_state_e      state_q, state_d;
    logic [IW-1:0]   ptr_q;
    logic [NUM_WARPS-1:0] stall_next, stall_q;
    logic [NUM_WARPS-1:0] elig;
    logic            step, hit;
    logic [IW-1:0]   winner;

    assign step = advance_i & ~issue_stall_i & ~fetch_stall_i;

    warp_stall_bits #(.NW(NUM_WARPS)) u_stall (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (stall_set_i),
        .clr_i        (stall_clr_i),
        .stall_next_o (stall_next),
        .stall_q_o    (stall_q)
    );

    assign elig = active_i & ~stall_next;

    warp_rr_picker #(.NW(NUM_WARPS), .IW(IW)) u_pick (
        .base_i   (ptr_q),
        .elig_i   (elig),
        .hit_o    (hit),
        .winner_o (winner)
    );

    // State register and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_OWNED;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (step && hit) begin
                ptr_q <= winner;
            end
        end
    end

    // Next state: LOSE and REGAIN transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_OWNED: if (step && !hit) state_d = SEL_EMPTY;
            SEL_EMPTY: if (step && hit)  state_d = SEL_OWNED;
            default:   state_d = SEL_OWNED;
        endcase
    end

    // Outputs
    always_comb begin
        warp_idx_o = ptr_q;
        unique case (state_q)
            SEL_OWNED: found_o = 1'b1;
            SEL_EMPTY: found_o = 1'b0;
            default:   found_o = 1'b0;
        endcase
    end

    // R2
    hold_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(warp_idx_o) && $stable(found_o)));

    // R5
    found_tracks_lap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (found_o == $past(|elig)));

    // R5
    miss_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(|elig)) |=> $stable(warp_idx_o));

    // R4
    winner_runnable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (active_i[winner] && !stall_next[winner]));

    // R3
    owner_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hit && (winner == ptr_q)) |-> ($countones(elig) == 1));

endmodule

// File: tb/warp_issue_selector_tb.sv
module warp_issue_selector_tb_top;

    localparam int NW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NW-1:0] active_i, stall_set_i, stall_clr_i;
    logic          advance_i, issue_stall_i, fetch_stall_i;
    logic [IW-1:0] warp_idx_o;
    logic          found_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    warp_issue_selector #(.NUM_WARPS(NW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_i      (active_i),
        .stall_set_i   (stall_set_i),
        .stall_clr_i   (stall_clr_i),
        .advance_i     (advance_i),
        .issue_stall_i (issue_stall_i),
        .fetch_stall_i (fetch_stall_i),
        .warp_idx_o    (warp_idx_o),
        .found_o       (found_o)
    );

    task automatic chk(input string req, input int exp_idx, input bit exp_f);
        total++;
        if (warp_idx_o !== IW'(exp_idx) || found_o !== exp_f) begin
            bad++;
            $display("FAIL %s: idx=%0d found=%0b expected idx=%0d found=%0b",
                     req, warp_idx_o, found_o, exp_idx, exp_f);
        end
    endtask

    // Drive inputs (called at negedge), run one edge, return at next negedge
    task automatic cyc(input logic [NW-1:0] act, input logic [NW-1:0] s,
                       input logic [NW-1:0] c, input bit adv,
                       input bit istl, input bit fstl);
        active_i      = act;
        stall_set_i   = s;
        stall_clr_i   = c;
        advance_i     = adv;
        issue_stall_i = istl;
        fetch_stall_i = fstl;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Arithmetic circular scan model
    function automatic void model(input int p, input logic [NW-1:0] a,
                                  input logic [NW-1:0] st,
                                  output int idx, output bit f);
        idx = p;
        f   = 1'b0;
        for (int k = 1; k <= NW; k++) begin
            int w;
            w = (p + k) % NW;
            if (!f && a[w] && !st[w]) begin
                idx = w;
                f   = 1'b1;
            end
        end
    endfunction

    // Steer the owner to p and clear every stall bit
    task automatic steer(input int p);
        cyc(NW'(1) << p, '0, '1, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: idx=%0d found=%0b expected finish", warp_idx_o, found_o);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ei;
        bit ef;
        rst_n = 1'b0;
        active_i = '0; stall_set_i = '0; stall_clr_i = '0;
        advance_i = 1'b0; issue_stall_i = 1'b0; fetch_stall_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, owner 0 found
        chk("R1 reset", 0, 1'b1);
        // R1: stall bits clear -> every warp reachable with no clear strobe
        cyc(4'b0010, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R1 stall bits clear", 1, 1'b1);

        // Exhaustive sweep: R3 R4 R5 R8
        for (int p = 0; p < NW; p++) begin
            for (int s = 0; s < (1 << NW); s++) begin
                for (int a = 0; a < (1 << NW); a++) begin
                    steer(p);
                    cyc('0, NW'(s), '0, 1'b0, 1'b0, 1'b0);
                    cyc(NW'(a), '0, '0, 1'b1, 1'b0, 1'b0);
                    model(p, NW'(a), NW'(s), ei, ef);
                    chk("R3/R4/R5 sweep", ei, ef);
                end
            end
        end

        // R8: only the owner runnable
        steer(2);
        cyc(4'b0100, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R8 self reselect", 2, 1'b1);

        // R2: blocked by issue stall, then by fetch stall, then no request
        steer(0);
        cyc(4'b1111, '0, '0, 1'b1, 1'b1, 1'b0);
        chk("R2 issue stall holds", 0, 1'b1);
        cyc(4'b1111, '0, '0, 1'b1, 1'b0, 1'b1);
        chk("R2 fetch stall holds", 0, 1'b1);
        cyc(4'b1111, '0, '0, 1'b0, 1'b0, 1'b0);
        chk("R2 no request holds", 0, 1'b1);
        cyc(4'b1111, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R3 advance after hold", 1, 1'b1);

        // R5: miss holds idx and found 0 survives blocked cycles, then regain
        steer(3);
        cyc(4'b0000, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R5 empty lap", 3, 1'b0);
        cyc(4'b1111, '0, '0, 1'b1, 1'b1, 1'b0);
        chk("R5 empty holds when blocked", 3, 1'b0);
        cyc(4'b0010, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R5 regain", 1, 1'b1);

        // R6: same-cycle set excludes the warp; bit persists; clear restores
        steer(0);
        cyc(4'b0100, 4'b0100, '0, 1'b1, 1'b0, 1'b0);
        chk("R6 same-cycle set excludes", 0, 1'b0);
        cyc(4'b0100, '0, '0, 1'b0, 1'b0, 1'b0);
        cyc(4'b0100, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R6 stall bit persists", 0, 1'b0);
        cyc(4'b0100, '0, 4'b0100, 1'b1, 1'b0, 1'b0);
        chk("R6 release same-cycle", 2, 1'b1);

        // R7: set and release together, release wins in-cycle and afterwards
        steer(0);
        cyc(4'b0010, 4'b0010, 4'b0010, 1'b1, 1'b0, 1'b0);
        chk("R7 conflict in-cycle", 1, 1'b1);
        steer(0);
        cyc('0, 4'b1000, 4'b1000, 1'b0, 1'b0, 1'b0);
        cyc(4'b1000, '0, '0, 1'b1, 1'b0, 1'b0);
        chk("R7 conflict leaves bit clear", 3, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule